// File: doc/BRIEF.md
# PHY PLL Calibration Sequencer

This block brings a USB 2.0 PHY's PLL and transmit path out of power-down and calibrates them. It follows one fixed timed procedure. When an accepted start arrives it loads every configuration field and raises the power-up enables. It then steps through a series of timed waits: it raises the VCO calibration start, fires a resistor calibration pulse of fixed width, and lets the analog circuits settle. Finally it polls the PLL-ready input once per millisecond, and a bounded number of checks decides whether the run ends in done or in timeout.

All time is counted in microsecond ticks. A tick is one clock cycle in which the `usTick` strobe is high, so the host chip chooses the real-time scale. A two-bit revision select chooses between two bit layouts of the PLL divider word. Any other revision value makes the block report an error and leave the PHY untouched. The analog PHY is outside the block, and so is any register access.

Top module: `pll_cal_seq`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` rises at the edge that accepts a start with a supported revision and stays high until the run ends in done or timeout. A `start` pulse while busy changes no output and no timing.
- R2: `revSel` = 0 selects the narrow divider layout: feedback divider in bits [7:0], reference divider in bits [11:8], so `pllDiv` = 0x0DF0. `revSel` = 1 selects the wide layout: feedback in bits [8:0], reference in bits [13:9], so `pllDiv` = 0x1AF0. The divider values are 0xF0 for feedback and 0xD for reference.
- R3: A start with `revSel` = 2 or 3 sets `revError` at the accepting edge. `busy` never rises, and every configuration and calibration output stays zero.
- R4: A supported start sets `pllPowerUp` = 1, `lockBypass` = 1, `cpCurrent` = 3, `vcoGain` = 3 and `calVolt` = 3 at the accepting edge.
- R5: The same edge sets `impThresh` = 2, `txSupply` = 3, `txAmp` = 4, `clkPhase` = 4, `slewRate` = 2, `squelchThresh` = 0xA, `anaPowerUp` = 1 and `otgPowerUp` = 1.
- R6: `vcoCalStart` rises at the edge that carries the VCO_WAIT-th tick counted after the accepting edge. A tick on the accepting edge itself is not counted. `vcoCalStart` then stays high until the next accepted start or reset.
- R7: `rcalStart` rises at the edge of tick VCO_WAIT+RCAL_WAIT and falls at the edge of tick VCO_WAIT+RCAL_WAIT+RCAL_PULSE.
- R8: The first ready check samples `pllReady` one cycle after the tick that completes SETTLE_WAIT. Each later check comes one cycle after a further POLL_PERIOD ticks. No tick is counted during a check cycle. `pllReady` high at a check sets `done` and ends the run.
- R9: If `pllReady` is low at all MAX_POLLS+1 checks, `timedOut` is set at the last check. `pllReady` high only between checks, or only before the first check, has no effect.
- R10: `done`, `timedOut` and `revError` stay set until the next accepted start, which clears them at its edge. At most one of them is high.
- R11: A synchronous active-high `rst` returns every output to zero at the next edge and aborts any run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| usTick | input | 1 | One-cycle strobe per microsecond |
| start | input | 1 | Request a power-up and calibration run |
| revSel | input | 2 | Silicon revision: 0 narrow layout, 1 wide layout, 2-3 unsupported |
| pllReady | input | 1 | PLL lock indication from the PHY |
| pllDiv | output | 14 | PLL divider word in the selected layout |
| pllPowerUp | output | 1 | PLL power-up enable |
| lockBypass | output | 1 | PLL lock bypass |
| cpCurrent | output | 3 | Charge-pump current |
| vcoGain | output | 3 | VCO gain |
| calVolt | output | 2 | Calibration supply voltage select |
| vcoCalStart | output | 1 | VCO calibration start level |
| rcalStart | output | 1 | Resistor calibration pulse |
| impThresh | output | 3 | Transmit impedance calibration threshold |
| txSupply | output | 2 | Transmit supply select |
| txAmp | output | 3 | Transmit amplitude |
| clkPhase | output | 4 | 60 MHz clock phase select |
| slewRate | output | 2 | Driver slew rate |
| squelchThresh | output | 4 | Receive squelch threshold |
| anaPowerUp | output | 1 | Analog block power-up |
| otgPowerUp | output | 1 | OTG block power-up |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run ended with the PLL ready |
| timedOut | output | 1 | Run ended without the PLL ready |
| revError | output | 1 | Start refused for an unsupported revision |

## Verification
The bench shortens the timing parameters so that complete runs fit in a few hundred cycles: VCO_WAIT 5, RCAL_WAIT 8, RCAL_PULSE 3, SETTLE_WAIT 6, POLL_PERIOD 10 and MAX_POLLS 4. It also gives a tick every third cycle. With these values the whole poll sequence is reachable, including the last check deciding between done and timeout. The gap between ticks also makes every check cycle tick-free, so the tick count at each edge is exact. The defaults remain the microsecond and millisecond values of the real procedure.

// File: rtl/pll_cal_seq_pkg.sv
package pll_cal_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_VCO, ST_RCAL, ST_PULSE, ST_SETTLE, ST_POLL
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic loadCfg;
    logic setVco;
    logic setRcal;
    logic clrRcal;
    logic setDone;
    logic setTimeout;
    logic setError;
  } seqStrobe_t;

  localparam logic [1:0] REV_NARROW = 2'd0;
  localparam logic [1:0] REV_WIDE   = 2'd1;

  localparam int DIV_W      = 14;
  localparam int FB_W_N     = 8;
  localparam int REF_SH_N   = 8;
  localparam int REF_W_N    = 4;
  localparam int FB_W_W     = 9;
  localparam int REF_SH_W   = 9;
  localparam int REF_W_W    = 5;
  localparam int FB_VAL     = 240;
  localparam int REF_VAL    = 13;

  localparam logic [DIV_W-1:0] DIV_WORD_N =
    DIV_W'(((REF_VAL % (1 << REF_W_N)) << REF_SH_N) | (FB_VAL % (1 << FB_W_N)));
  localparam logic [DIV_W-1:0] DIV_WORD_W =
    DIV_W'(((REF_VAL % (1 << REF_W_W)) << REF_SH_W) | (FB_VAL % (1 << FB_W_W)));

  typedef struct packed {
    logic [DIV_W-1:0] pllDiv;
    logic             pllPowerUp;
    logic             lockBypass;
    logic [2:0]       cpCurrent;
    logic [2:0]       vcoGain;
    logic [1:0]       calVolt;
    logic [2:0]       impThresh;
    logic [1:0]       txSupply;
    logic [2:0]       txAmp;
    logic [3:0]       clkPhase;
    logic [1:0]       slewRate;
    logic [3:0]       squelchThresh;
    logic             anaPowerUp;
    logic             otgPowerUp;
  } phyCfg_t;

  typedef struct packed {
    logic vcoCalStart;
    logic rcalStart;
    logic done;
    logic timedOut;
    logic revError;
  } seqStat_t;

endpackage

// File: rtl/pll_cal_seq_ctrl.sv
module pll_cal_seq_ctrl
  import pll_cal_seq_pkg::*;
#(
  parameter int VCO_WAIT    = 200,
  parameter int RCAL_WAIT   = 400,
  parameter int RCAL_PULSE  = 40,
  parameter int SETTLE_WAIT = 400,
  parameter int POLL_PERIOD = 1000,
  parameter int MAX_POLLS   = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       usTick,
  input  logic       start,
  input  logic [1:0] revSel,
  input  logic       pllReady,
  output logic       busy,
  output seqStrobe_t strb
);

  localparam int LONG_A  = (VCO_WAIT > RCAL_WAIT) ? VCO_WAIT : RCAL_WAIT;
  localparam int LONG_B  = (RCAL_PULSE > SETTLE_WAIT) ? RCAL_PULSE : SETTLE_WAIT;
  localparam int LONG_C  = (LONG_A > LONG_B) ? LONG_A : LONG_B;
  localparam int LONGEST = (LONG_C > POLL_PERIOD) ? LONG_C : POLL_PERIOD;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam int IDX_W   = $clog2(MAX_POLLS + 1);

  seqState_t        state, nxt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] phaseLen;
  logic [IDX_W-1:0] pollIdx;
  logic             checkDue;
  logic             windowEnd;
  logic             revOk;

  always_comb begin
    case (state)
      ST_VCO:    phaseLen = CNT_W'(VCO_WAIT);
      ST_RCAL:   phaseLen = CNT_W'(RCAL_WAIT);
      ST_PULSE:  phaseLen = CNT_W'(RCAL_PULSE);
      ST_SETTLE: phaseLen = CNT_W'(SETTLE_WAIT);
      ST_POLL:   phaseLen = CNT_W'(POLL_PERIOD);
      default:   phaseLen = CNT_W'(1);
    endcase
  end

  assign windowEnd = usTick && (cnt == phaseLen - CNT_W'(1));
  assign revOk     = (revSel == REV_NARROW) || (revSel == REV_WIDE);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strb = '0;
    nxt  = state;
    case (state)
      ST_IDLE: if (start) begin
        strb.clrAll = 1'b1;
        if (revOk) begin
          strb.loadCfg = 1'b1;
          nxt          = ST_VCO;
        end else begin
          strb.setError = 1'b1;
        end
      end
      ST_VCO: if (windowEnd) begin
        strb.setVco = 1'b1;
        nxt         = ST_RCAL;
      end
      ST_RCAL: if (windowEnd) begin
        strb.setRcal = 1'b1;
        nxt          = ST_PULSE;
      end
      ST_PULSE: if (windowEnd) begin
        strb.clrRcal = 1'b1;
        nxt          = ST_SETTLE;
      end
      ST_SETTLE: if (windowEnd) nxt = ST_POLL;
      ST_POLL: if (checkDue) begin
        if (pllReady) begin
          strb.setDone = 1'b1;
          nxt          = ST_IDLE;
        end else if (pollIdx == IDX_W'(MAX_POLLS)) begin
          strb.setTimeout = 1'b1;
          nxt             = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      pollIdx  <= '0;
      checkDue <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state) begin
        cnt      <= '0;
        pollIdx  <= '0;
        checkDue <= (nxt == ST_POLL);
      end else if (state == ST_POLL && checkDue) begin
        checkDue <= 1'b0;
        pollIdx  <= pollIdx + IDX_W'(1);
      end else if (state != ST_IDLE && usTick) begin
        if (windowEnd) begin
          cnt      <= '0;
          checkDue <= (state == ST_POLL);
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pll_cal_seq_dp.sv
module pll_cal_seq_dp
  import pll_cal_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strb,
  input  logic [1:0] revSel,
  output phyCfg_t    cfg,
  output seqStat_t   stat
);

  phyCfg_t loadVal;

  always_comb begin
    loadVal               = '0;
    loadVal.pllDiv        = (revSel == REV_WIDE) ? DIV_WORD_W : DIV_WORD_N;
    loadVal.pllPowerUp    = 1'b1;
    loadVal.lockBypass    = 1'b1;
    loadVal.cpCurrent     = 3'd3;
    loadVal.vcoGain       = 3'd3;
    loadVal.calVolt       = 2'd3;
    loadVal.impThresh     = 3'd2;
    loadVal.txSupply      = 2'd3;
    loadVal.txAmp         = 3'd4;
    loadVal.clkPhase      = 4'd4;
    loadVal.slewRate      = 2'd2;
    loadVal.squelchThresh = 4'hA;
    loadVal.anaPowerUp    = 1'b1;
    loadVal.otgPowerUp    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg  <= '0;
      stat <= '0;
    end else begin
      if (strb.clrAll) begin
        cfg  <= '0;
        stat <= '0;
      end
      if (strb.loadCfg)    cfg <= loadVal;
      if (strb.setVco)     stat.vcoCalStart <= 1'b1;
      if (strb.setRcal)    stat.rcalStart   <= 1'b1;
      if (strb.clrRcal)    stat.rcalStart   <= 1'b0;
      if (strb.setDone)    stat.done        <= 1'b1;
      if (strb.setTimeout) stat.timedOut    <= 1'b1;
      if (strb.setError)   stat.revError    <= 1'b1;
    end
  end

endmodule

// File: rtl/pll_cal_seq.sv
module pll_cal_seq
  import pll_cal_seq_pkg::*;
#(
  parameter int VCO_WAIT    = 200,
  parameter int RCAL_WAIT   = 400,
  parameter int RCAL_PULSE  = 40,
  parameter int SETTLE_WAIT = 400,
  parameter int POLL_PERIOD = 1000,
  parameter int MAX_POLLS   = 100
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        usTick,
  input  logic        start,
  input  logic [1:0]  revSel,
  input  logic        pllReady,
  output logic [13:0] pllDiv,
  output logic        pllPowerUp,
  output logic        lockBypass,
  output logic [2:0]  cpCurrent,
  output logic [2:0]  vcoGain,
  output logic [1:0]  calVolt,
  output logic        vcoCalStart,
  output logic        rcalStart,
  output logic [2:0]  impThresh,
  output logic [1:0]  txSupply,
  output logic [2:0]  txAmp,
  output logic [3:0]  clkPhase,
  output logic [1:0]  slewRate,
  output logic [3:0]  squelchThresh,
  output logic        anaPowerUp,
  output logic        otgPowerUp,
  output logic        busy,
  output logic        done,
  output logic        timedOut,
  output logic        revError
);

  seqStrobe_t strb;
  phyCfg_t    cfg;
  seqStat_t   stat;

  pll_cal_seq_ctrl #(
    .VCO_WAIT   (VCO_WAIT),
    .RCAL_WAIT  (RCAL_WAIT),
    .RCAL_PULSE (RCAL_PULSE),
    .SETTLE_WAIT(SETTLE_WAIT),
    .POLL_PERIOD(POLL_PERIOD),
    .MAX_POLLS  (MAX_POLLS)
  ) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .usTick  (usTick),
    .start   (start),
    .revSel  (revSel),
    .pllReady(pllReady),
    .busy    (busy),
    .strb    (strb)
  );

  pll_cal_seq_dp dp_i (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .revSel(revSel),
    .cfg   (cfg),
    .stat  (stat)
  );

  assign pllDiv        = cfg.pllDiv;
  assign pllPowerUp    = cfg.pllPowerUp;
  assign lockBypass    = cfg.lockBypass;
  assign cpCurrent     = cfg.cpCurrent;
  assign vcoGain       = cfg.vcoGain;
  assign calVolt       = cfg.calVolt;
  assign impThresh     = cfg.impThresh;
  assign txSupply      = cfg.txSupply;
  assign txAmp         = cfg.txAmp;
  assign clkPhase      = cfg.clkPhase;
  assign slewRate      = cfg.slewRate;
  assign squelchThresh = cfg.squelchThresh;
  assign anaPowerUp    = cfg.anaPowerUp;
  assign otgPowerUp    = cfg.otgPowerUp;
  assign vcoCalStart   = stat.vcoCalStart;
  assign rcalStart     = stat.rcalStart;
  assign done          = stat.done;
  assign timedOut      = stat.timedOut;
  assign revError      = stat.revError;

endmodule

// File: rtl/pll_cal_seq_chk.sv
module pll_cal_seq_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic pllReady,
  input logic pllPowerUp,
  input logic vcoCalStart,
  input logic rcalStart,
  input logic busy,
  input logic done,
  input logic timedOut,
  input logic revError
);

  p_busy_from_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  p_busy_no_status_r1: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(done || timedOut || revError));

  p_error_no_run_r3: assert property (@(posedge clk) disable iff (rst)
    revError |-> (!busy && !pllPowerUp && !vcoCalStart));

  p_vco_held_r6: assert property (@(posedge clk) disable iff (rst)
    (vcoCalStart && !(start && !busy)) |=> vcoCalStart);

  p_rcal_inside_run_r7: assert property (@(posedge clk) disable iff (rst)
    rcalStart |-> (vcoCalStart && busy));

  p_done_needs_ready_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(pllReady));

  p_timeout_no_ready_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(timedOut) |-> !$past(pllReady));

  p_status_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, timedOut, revError}));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  p_reset_clears_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(busy || done || timedOut || revError || pllPowerUp || vcoCalStart || rcalStart));

endmodule

bind pll_cal_seq pll_cal_seq_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .pllReady   (pllReady),
  .pllPowerUp (pllPowerUp),
  .vcoCalStart(vcoCalStart),
  .rcalStart  (rcalStart),
  .busy       (busy),
  .done       (done),
  .timedOut   (timedOut),
  .revError   (revError)
);

// File: tb/pll_cal_seq_tb_top.sv
module pll_cal_seq_tb_top;

  localparam int VCO    = 5;
  localparam int RCAL   = 8;
  localparam int PULSE  = 3;
  localparam int SETTLE = 6;
  localparam int POLL   = 10;
  localparam int MAXP   = 4;
  localparam int SUM    = VCO + RCAL + PULSE + SETTLE;
  localparam int TMO    = SUM + MAXP * POLL;
  localparam int NEVER  = 100000;
  localparam int WDOG   = 20000;

  // expected outcome: 1 done, 2 timeout, 3 revision error
  typedef struct packed {
    logic [1:0]  rev;
    logic [1:0]  outcome;
    int unsigned rdyOn;
    int unsigned rdyOff;
    int unsigned endTicks;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'd0, 2'd1, 0,                  NEVER,        SUM},         // R8 ready at first check
    '{2'd1, 2'd1, 0,                  NEVER,        SUM},         // R2 wide layout
    '{2'd0, 2'd2, NEVER,              NEVER,        TMO},         // R9 never ready
    '{2'd1, 2'd1, SUM + 1,            NEVER,        SUM + POLL},  // R8 second check
    '{2'd0, 2'd1, SUM + (MAXP-1)*POLL + 1, NEVER,   TMO},         // R8 last check
    '{2'd0, 2'd2, SUM + 1,            SUM + 5,      TMO},         // R9 glitch between checks
    '{2'd1, 2'd2, 0,                  SUM,          TMO},         // R9 ready only before polling
    '{2'd2, 2'd3, 0,                  NEVER,        0},           // R3
    '{2'd3, 2'd3, 0,                  NEVER,        0}            // R3
  };

  logic        clk;
  logic        rst;
  logic        usTick;
  logic        start;
  logic [1:0]  revSel;
  logic        pllReady;
  logic [13:0] pllDiv;
  logic        pllPowerUp, lockBypass;
  logic [2:0]  cpCurrent, vcoGain;
  logic [1:0]  calVolt;
  logic        vcoCalStart, rcalStart;
  logic [2:0]  impThresh;
  logic [1:0]  txSupply;
  logic [2:0]  txAmp;
  logic [3:0]  clkPhase;
  logic [1:0]  slewRate;
  logic [3:0]  squelchThresh;
  logic        anaPowerUp, otgPowerUp;
  logic        busy, done, timedOut, revError;

  int nChecks = 0;
  int nFail   = 0;
  int tickCnt = 0;
  int rdyOn   = NEVER;
  int rdyOff  = NEVER;
  int cycles  = 0;
  int divPh   = 0;
  logic busyPrev = 1'b0;
  logic vcoPrev  = 1'b0;
  logic rcalPrev = 1'b0;

  assign pllReady = (tickCnt >= rdyOn) && (tickCnt < rdyOff);

  wire [49:0] allOut = {pllDiv, pllPowerUp, lockBypass, cpCurrent, vcoGain, calVolt,
                        vcoCalStart, rcalStart, impThresh, txSupply, txAmp, clkPhase,
                        slewRate, squelchThresh, anaPowerUp, otgPowerUp,
                        busy, done, timedOut, revError};

  initial clk = 1'b0;
  always #5 clk = ~clk;

  pll_cal_seq #(
    .VCO_WAIT(VCO), .RCAL_WAIT(RCAL), .RCAL_PULSE(PULSE),
    .SETTLE_WAIT(SETTLE), .POLL_PERIOD(POLL), .MAX_POLLS(MAXP)
  ) dut_i (
    .clk(clk), .rst(rst), .usTick(usTick), .start(start), .revSel(revSel),
    .pllReady(pllReady), .pllDiv(pllDiv), .pllPowerUp(pllPowerUp),
    .lockBypass(lockBypass), .cpCurrent(cpCurrent), .vcoGain(vcoGain),
    .calVolt(calVolt), .vcoCalStart(vcoCalStart), .rcalStart(rcalStart),
    .impThresh(impThresh), .txSupply(txSupply), .txAmp(txAmp),
    .clkPhase(clkPhase), .slewRate(slewRate), .squelchThresh(squelchThresh),
    .anaPowerUp(anaPowerUp), .otgPowerUp(otgPowerUp), .busy(busy),
    .done(done), .timedOut(timedOut), .revError(revError)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tick generation, tick counting and calibration timing monitor
  initial usTick = 1'b0;
  always @(negedge clk) begin
    cycles++;
    if (busyPrev && usTick) tickCnt++;
    if (busy && !busyPrev) tickCnt = 0;
    if (busy && vcoCalStart && !vcoPrev)
      chk(tickCnt == VCO, "R6 vco start tick", tickCnt, VCO);
    if (busy && rcalStart && !rcalPrev)
      chk(tickCnt == VCO + RCAL, "R7 rcal rise tick", tickCnt, VCO + RCAL);
    if (busy && !rcalStart && rcalPrev)
      chk(tickCnt == VCO + RCAL + PULSE, "R7 rcal fall tick", tickCnt, VCO + RCAL + PULSE);
    busyPrev = busy;
    vcoPrev  = vcoCalStart;
    rcalPrev = rcalStart;
    divPh    = (divPh + 1) % 3;
    usTick   = (divPh == 0);
    if (cycles == WDOG) begin
      chk(1'b0, "R1 watchdog expired", cycles, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic pulseStart();
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic waitEnd();
    for (int w = 0; w < 3000 && !(done || timedOut || revError); w++) step();
  endtask

  task automatic waitTicks(input int n);
    for (int w = 0; w < 3000 && tickCnt < n; w++) step();
  endtask

  task automatic runVec(input vec_t v);
    revSel = v.rev;
    rdyOn  = int'(v.rdyOn);
    rdyOff = int'(v.rdyOff);
    pulseStart();
    waitEnd();
    chk(done == (v.outcome == 2'd1), "R8 done flag", done, v.outcome == 2'd1);
    chk(timedOut == (v.outcome == 2'd2), "R9 timeout flag", timedOut, v.outcome == 2'd2);
    chk(revError == (v.outcome == 2'd3), "R3 error flag", revError, v.outcome == 2'd3);
    chk(!busy, "R1 busy low at end", busy, 0);
    if (v.outcome == 2'd3) begin
      chk(allOut[49:4] == '0, "R3 controls untouched", allOut[49:4], 0);
    end else begin
      chk(tickCnt == int'(v.endTicks), "R8 end tick", tickCnt, v.endTicks);
      chk(pllDiv == ((v.rev == 2'd1) ? 14'h1AF0 : 14'h0DF0), "R2 divider word", pllDiv,
          (v.rev == 2'd1) ? 14'h1AF0 : 14'h0DF0);
      chk({pllPowerUp, lockBypass, cpCurrent, vcoGain, calVolt} == {1'b1, 1'b1, 3'd3, 3'd3, 2'd3},
          "R4 pll fields", {pllPowerUp, lockBypass, cpCurrent, vcoGain, calVolt},
          {1'b1, 1'b1, 3'd3, 3'd3, 2'd3});
      chk({impThresh, txSupply, txAmp, clkPhase, slewRate, squelchThresh, anaPowerUp, otgPowerUp}
          == {3'd2, 2'd3, 3'd4, 4'd4, 2'd2, 4'hA, 1'b1, 1'b1}, "R5 tx rx fields",
          {impThresh, txSupply, txAmp, clkPhase, slewRate, squelchThresh, anaPowerUp, otgPowerUp},
          {3'd2, 2'd3, 3'd4, 4'd4, 2'd2, 4'hA, 1'b1, 1'b1});
      chk(vcoCalStart && !rcalStart, "R6 vco held, rcal low", {vcoCalStart, rcalStart}, 2'b10);
    end
  endtask

  initial begin
    rst    = 1'b1;
    start  = 1'b0;
    revSel = 2'd0;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk(allOut == '0, "R11 reset state", allOut, 0);

    for (int i = 0; i < 9; i++) runVec(VECS[i]);

    // R10: a new start clears the error left by the last vector
    revSel = 2'd0;
    rdyOn  = 0;
    rdyOff = NEVER;
    pulseStart();
    chk(!revError && busy, "R10 error cleared by start", {revError, busy}, 2'b01);
    waitEnd();
    repeat (20) step();
    chk(done && !busy, "R10 done sticky", {done, busy}, 2'b10);

    // R10 clear of done, R1 start ignored while busy
    pulseStart();
    chk(!done && busy, "R10 done cleared by start", {done, busy}, 2'b01);
    waitTicks(VCO + 2);
    revSel = 2'd3;
    pulseStart();
    chk(busy && !revError, "R1 start ignored while busy", {busy, revError}, 2'b10);
    waitEnd();
    chk(done && tickCnt == SUM, "R1 run timing unchanged", tickCnt, SUM);
    chk(pllDiv == 14'h0DF0, "R1 divider unchanged", pllDiv, 14'h0DF0);

    // R11: reset in the middle of the calibration pulse
    revSel = 2'd1;
    pulseStart();
    waitTicks(VCO + RCAL + 1);
    chk(rcalStart, "R7 pulse active before reset", rcalStart, 1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk(allOut == '0, "R11 reset mid-run", allOut, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule